// File: doc/BRIEF.md
# Interrupt Redirection Table Dispatcher

This block keeps a table of 64-bit redirection entries, one for each external interrupt input pin. Software programs the table through a register port in 32-bit halves. Each entry sets the vector, the delivery mode, how the destination is read, the trigger type, the input polarity and a mask. A scan pointer visits the entries one per cycle in ascending order and wraps after the last one. When it reaches an unmasked entry that has work to do, it loads a delivery message and offers it on a valid/ready output. The pointer then waits until that message is accepted.

Edge-triggered entries latch a pending flag on the active edge of their pin. Level-triggered Fixed and Lowest Priority entries set a remote-IRR bit when their message is accepted. That bit blocks further deliveries from the entry until an end-of-interrupt arrives whose vector matches the entry's vector. NMI and INIT entries never use remote-IRR. If one of them is set to level, it delivers again every time the scan returns to it while its pin is still active. SMI and ExtINT messages always carry a zero vector.

The controller has two states. ST_SCAN looks at the entry under the pointer. If the entry is eligible, the controller moves to ST_SEND, and if not, the pointer advances. ST_SEND holds msg_valid high. When msg_ready is seen, the transfer completes: the controller clears the pending flag or sets remote-IRR, advances the pointer and returns to ST_SCAN.

Top module: `irq_redir_dispatch`

## Requirements
- R1: After reset, every entry reads low half 0x00010000 (only the mask bit 16 set) and high half 0, and msg_valid is low.
- R2: A write with cfg_hi=0 stores bits 31:0 of the entry and a write with cfg_hi=1 stores bits 63:32. Both halves read back on cfg_rdata in the same cycle they are addressed. Bit 14 (remote-IRR) is read-only, so writing 1 to it reads back 0 while remote-IRR is clear.
- R3: An unmasked edge-triggered entry (bit 15 = 0) produces exactly one message per active edge of its pin. Bit 13 = 1 makes the pin active low.
- R4: An active edge that arrives while the entry's mask bit 16 is 1 is dropped, so unmasking the entry afterwards produces no message.
- R5: A level-triggered (bit 15 = 1) Fixed (bits 10:8 = 000) or Lowest Priority (001) entry delivers once and sets remote-IRR (bit 14) on acceptance. It then stays silent while remote-IRR is set. eoi_valid with a matching eoi_vector clears remote-IRR, and an EOI with a different vector has no effect.
- R6: An NMI (100) or INIT (101) entry set to level is resent each time the scan comes back to it while its pin is active, and it never sets remote-IRR.
- R7: SMI (010) and ExtINT (111) messages carry msg_vector = 0 whatever the entry's bits 7:0 hold.
- R8: Entries with reserved modes 011 or 110 never produce a message.
- R9: msg_dest_logical equals bit 11. When it is 0, msg_dest is {4'b0, bits 59:56}. When it is 1, msg_dest is bits 63:56. msg_mode is bits 10:8 and msg_vector is bits 7:0.
- R10: Only one message is outstanding at a time. While msg_valid is high and msg_ready is low, all message fields hold steady and the scan stops. An entry made pending during the stall is delivered after the stalled message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NUM_PINS | Interrupt input pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_hi | input | 1 | Selects bits 63:32 (1) or 31:0 (0) |
| cfg_idx | input | IDX_W | Entry index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed half |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode code |
| msg_dest_logical | output | 1 | Destination is logical |
| msg_dest | output | 8 | Destination field |

## Verification
The checker tests four things on every cycle:
- message fields hold steady while a message is stalled;
- reserved mode codes never appear on the output;
- SMI and ExtINT messages carry a zero vector;
- physical destinations never use the upper nibble.

The bench scenarios cover the behaviour that only shows up as a sequence:
- dropping an edge that arrives while the entry is masked;
- remote-IRR blocking further deliveries and its release by EOI;
- the repeated resend of a level-held NMI;
- delivery order across a stall.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWEST = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV3   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_RSV6   = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_t;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_SEND = 1'b1
    } disp_state_t;

    typedef struct packed {
        logic [7:0] vector;
        dmode_t     mode;
        logic       logical;
        logic [7:0] dest;
    } irq_msg_t;

    localparam int BIT_MASK = 16;
    localparam int BIT_TRIG = 15;
    localparam int BIT_RIRR = 14;
    localparam int BIT_POL  = 13;
    localparam int BIT_DLOG = 11;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;

    function automatic logic mode_reserved(input dmode_t m);
        return (m == DM_RSV3) || (m == DM_RSV6);
    endfunction

    function automatic logic mode_uses_rirr(input dmode_t m);
        return (m == DM_FIXED) || (m == DM_LOWEST);
    endfunction

    function automatic logic mode_may_level(input dmode_t m);
        return mode_uses_rirr(m) || (m == DM_NMI) || (m == DM_INIT);
    endfunction

    function automatic logic mode_zero_vec(input dmode_t m);
        return (m == DM_SMI) || (m == DM_EXTINT);
    endfunction

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pol_low,
    output logic [NUM_PINS-1:0] act,
    output logic [NUM_PINS-1:0] rise
);
    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
        logic act_q;
        assign act[gp]  = pin_in[gp] ^ pol_low[gp];
        assign rise[gp] = act[gp] & ~act_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) act_q <= 1'b0;
            else        act_q <= act[gp];
        end
    end
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_hi,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [NUM_PINS-1:0] act,
    input  logic [NUM_PINS-1:0] rise,
    input  logic [IDX_W-1:0]    scan_idx,
    input  logic                done,
    input  logic                rirr_set,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic [NUM_PINS-1:0] pol_low,
    output logic                cur_elig,
    output logic [31:0]         cur_lo,
    output logic [31:0]         cur_hi
);
    logic [31:0]         lo_q [NUM_PINS];
    logic [31:0]         hi_q [NUM_PINS];
    logic [NUM_PINS-1:0] elig;
    logic [NUM_PINS-1:0] rirr_vec;

    for (genvar ge = 0; ge < NUM_PINS; ge++) begin : g_ent
        logic   pend_q, rirr_q, sel, lvl_kind;
        dmode_t md;
        assign sel      = cfg_we && (cfg_idx == IDX_W'(ge));
        assign md       = dmode_t'(lo_q[ge][10:8]);
        assign lvl_kind = lo_q[ge][BIT_TRIG] && mode_may_level(md);
        assign pol_low[ge]  = lo_q[ge][BIT_POL];
        assign rirr_vec[ge] = rirr_q;
        assign elig[ge] = !lo_q[ge][BIT_MASK] && !mode_reserved(md) &&
                          (lvl_kind ? (act[ge] && !(mode_uses_rirr(md) && rirr_q))
                                    : pend_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[ge] <= LO_RESET;
                hi_q[ge] <= '0;
                pend_q   <= 1'b0;
                rirr_q   <= 1'b0;
            end else begin
                if (sel && !cfg_hi) lo_q[ge] <= cfg_wdata;
                if (sel &&  cfg_hi) hi_q[ge] <= cfg_wdata;
                if (rise[ge] && !lo_q[ge][BIT_MASK] && !lvl_kind)
                    pend_q <= 1'b1;
                else if (done && scan_idx == IDX_W'(ge))
                    pend_q <= 1'b0;
                if (rirr_set && done && scan_idx == IDX_W'(ge))
                    rirr_q <= 1'b1;
                else if (eoi_valid && rirr_q && eoi_vector == lo_q[ge][7:0])
                    rirr_q <= 1'b0;
            end
        end
    end

    assign cur_elig = elig[scan_idx];
    assign cur_lo   = lo_q[scan_idx];
    assign cur_hi   = hi_q[scan_idx];

    always_comb begin
        cfg_rdata = '0;
        if (32'(cfg_idx) < NUM_PINS) begin
            if (cfg_hi) cfg_rdata = hi_q[cfg_idx];
            else        cfg_rdata = {lo_q[cfg_idx][31:BIT_RIRR+1], rirr_vec[cfg_idx],
                                     lo_q[cfg_idx][BIT_RIRR-1:0]};
        end
    end
endmodule

// File: rtl/irq_redir_dispatch.sv
module irq_redir_dispatch
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                cfg_we,
    input  logic                cfg_hi,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic                msg_dest_logical,
    output logic [7:0]          msg_dest
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

    disp_state_t         state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    irq_msg_t            msg_q, msg_d;
    logic                rirr_pend_q;
    logic                done, cur_elig;
    logic [31:0]         cur_lo, cur_hi;
    logic [NUM_PINS-1:0] act, rise, pol_low;
    dmode_t              cur_mode;

    irq_pin_front #(.NUM_PINS(NUM_PINS)) u_front (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol_low(pol_low),
        .act(act), .rise(rise)
    );

    irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .act(act), .rise(rise), .scan_idx(idx_q), .done(done),
        .rirr_set(rirr_pend_q), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .pol_low(pol_low), .cur_elig(cur_elig), .cur_lo(cur_lo), .cur_hi(cur_hi)
    );

    assign cur_mode = dmode_t'(cur_lo[10:8]);

    always_comb begin
        msg_d.vector  = mode_zero_vec(cur_mode) ? 8'h00 : cur_lo[7:0];
        msg_d.mode    = cur_mode;
        msg_d.logical = cur_lo[BIT_DLOG];
        msg_d.dest    = cur_lo[BIT_DLOG] ? cur_hi[31:24] : {4'b0000, cur_hi[27:24]};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN: if (cur_elig)  state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_SCAN;
            idx_q       <= '0;
            msg_q       <= '0;
            rirr_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SCAN && cur_elig) begin
                msg_q       <= msg_d;
                rirr_pend_q <= cur_lo[BIT_TRIG] && mode_uses_rirr(cur_mode);
            end
            if ((state_q == ST_SCAN && !cur_elig) || done)
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        msg_valid        = (state_q == ST_SEND);
        done             = msg_valid && msg_ready;
        msg_vector       = msg_q.vector;
        msg_mode         = msg_q.mode;
        msg_dest_logical = msg_q.logical;
        msg_dest         = msg_q.dest;
    end
endmodule

// File: rtl/irq_redir_checker.sv
module irq_redir_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       msg_valid,
    input logic       msg_ready,
    input logic [7:0] msg_vector,
    input logic [2:0] msg_mode,
    input logic       msg_dest_logical,
    input logic [7:0] msg_dest
);
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
        $stable(msg_mode) && $stable(msg_dest_logical) && $stable(msg_dest));

    p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_mode != 3'b011) && (msg_mode != 3'b110));

    p_zero_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_mode == 3'b010 || msg_mode == 3'b111) |-> msg_vector == 8'h00);

    p_phys_nibble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_dest_logical |-> msg_dest[7:4] == 4'h0);
endmodule

bind irq_redir_dispatch irq_redir_checker u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest)
);

// File: tb/tb_irq_redir_dispatch.sv
module tb_irq_redir_dispatch;
    localparam int NP = 24;
    logic          clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          cfg_we = 1'b0, cfg_hi = 1'b0;
    logic [4:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0, cfg_rdata;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid, msg_ready = 1'b1;
    logic [7:0]    msg_vector, msg_dest;
    logic [2:0]    msg_mode;
    logic          msg_dest_logical;

    int n_chk = 0, n_bad = 0, n_count = 0;
    bit count_mode = 1'b0;
    logic [19:0] count_tpl = '0;
    logic [19:0] exp_q[$];
    string cur_req = "R1";

    always #5 clk = ~clk;

    irq_redir_dispatch dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int idx, bit hi, logic [31:0] d);
        cfg_we = 1'b1; cfg_hi = hi; cfg_idx = 5'(idx); cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int idx, bit hi, logic [31:0] exp);
        cfg_hi = hi; cfg_idx = 5'(idx);
        @(negedge clk);
        check(req, cfg_rdata, exp);
        tick(1);
    endtask

    task automatic expect_msg(logic [7:0] v, logic [2:0] m, logic l, logic [7:0] d);
        exp_q.push_back({v, m, l, d});
    endtask

    task automatic pulse(int p);
        pin_in[p] = ~pin_in[p]; tick(2); pin_in[p] = ~pin_in[p];
    endtask

    task automatic drained(string req);
        tick(40);
        check(req, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic eoi(logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v; tick(1); eoi_valid = 1'b0;
    endtask

    // monitor: pops expected messages at each completed handshake
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (count_mode) begin
                n_count++;
                check(cur_req, {12'b0, msg_vector, msg_mode, msg_dest_logical, msg_dest},
                      {12'b0, count_tpl});
            end else if (exp_q.size() == 0) begin
                check(cur_req, {12'b0, msg_vector, msg_mode, msg_dest_logical, msg_dest},
                      32'hFFFF_FFFF);
            end else begin
                logic [19:0] e;
                e = exp_q.pop_front();
                check(cur_req, {12'b0, msg_vector, msg_mode, msg_dest_logical, msg_dest},
                      {12'b0, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset contents
        for (int i = 0; i < NP; i++) begin
            rd_chk("R1", i, 1'b0, 32'h0001_0000);
            rd_chk("R1", i, 1'b1, 32'h0000_0000);
        end
        @(negedge clk); check("R1", {31'b0, msg_valid}, 32'd0); tick(1);

        // R2 halves and read-only remote-IRR
        cur_req = "R2";
        wr(3, 1'b0, 32'h0001_6035);
        wr(3, 1'b1, 32'hA500_0000);
        rd_chk("R2", 3, 1'b0, 32'h0001_2035);
        rd_chk("R2", 3, 1'b1, 32'hA500_0000);

        // R3 edge fixed, active high, then active low
        cur_req = "R3";
        wr(2, 1'b1, 32'h0300_0000);
        wr(2, 1'b0, 32'h0000_0041);
        expect_msg(8'h41, 3'b000, 1'b0, 8'h03);
        pulse(2);
        drained("R3");
        pin_in[5] = 1'b1; tick(2);
        wr(5, 1'b1, 32'h0F00_0000);
        wr(5, 1'b0, 32'h0000_2152);
        tick(30);
        expect_msg(8'h52, 3'b001, 1'b0, 8'h0F);
        pulse(5);
        drained("R3");

        // R4 edge while masked is lost
        cur_req = "R4";
        wr(7, 1'b0, 32'h0001_0060);
        pulse(7);
        tick(3);
        wr(7, 1'b0, 32'h0000_0060);
        drained("R4");

        // R5 level fixed with remote-IRR and EOI
        cur_req = "R5";
        wr(9, 1'b1, 32'h0100_0000);
        wr(9, 1'b0, 32'h0000_8077);
        expect_msg(8'h77, 3'b000, 1'b0, 8'h01);
        pin_in[9] = 1'b1;
        tick(60);
        check("R5", 32'(exp_q.size()), 32'd0);
        rd_chk("R5", 9, 1'b0, 32'h0000_C077);
        eoi(8'h78);
        tick(40);
        rd_chk("R5", 9, 1'b0, 32'h0000_C077);
        expect_msg(8'h77, 3'b000, 1'b0, 8'h01);
        eoi(8'h77);
        drained("R5");
        rd_chk("R5", 9, 1'b0, 32'h0000_C077);
        pin_in[9] = 1'b0;
        eoi(8'h77);
        tick(2);
        rd_chk("R5", 9, 1'b0, 32'h0000_8077);
        drained("R5");

        // R6 level NMI resends, no remote-IRR
        cur_req = "R6";
        wr(11, 1'b0, 32'h0000_8400);
        count_tpl = {8'h00, 3'b100, 1'b0, 8'h00};
        n_count = 0;
        count_mode = 1'b1;
        pin_in[11] = 1'b1;
        tick(200);
        rd_chk("R6", 11, 1'b0, 32'h0000_8400);
        pin_in[11] = 1'b0;
        tick(30);
        count_mode = 1'b0;
        check("R6", 32'(n_count >= 5), 32'd1);

        // R7 SMI and ExtINT zero vector (ExtINT also logical destination, R9)
        cur_req = "R7";
        wr(12, 1'b1, 32'h0200_0000);
        wr(12, 1'b0, 32'h0000_0299);
        expect_msg(8'h00, 3'b010, 1'b0, 8'h02);
        pulse(12);
        drained("R7");
        wr(13, 1'b1, 32'hC500_0000);
        wr(13, 1'b0, 32'h0000_0FAB);
        expect_msg(8'h00, 3'b111, 1'b1, 8'hC5);
        pulse(13);
        drained("R7");

        // R8 reserved modes silent
        cur_req = "R8";
        wr(14, 1'b0, 32'h0000_0333);
        wr(15, 1'b0, 32'h0000_8644);
        pulse(14);
        pin_in[15] = 1'b1;
        drained("R8");
        pin_in[15] = 1'b0;

        // R9 physical vs logical destination
        cur_req = "R9";
        wr(16, 1'b1, 32'hAB00_0000);
        wr(16, 1'b0, 32'h0000_0120);
        expect_msg(8'h20, 3'b001, 1'b0, 8'h0B);
        pulse(16);
        drained("R9");
        wr(17, 1'b1, 32'hAB00_0000);
        wr(17, 1'b0, 32'h0000_0921);
        expect_msg(8'h21, 3'b001, 1'b1, 8'hAB);
        pulse(17);
        drained("R9");

        // R10 stall holds fields, later entry waits
        cur_req = "R10";
        wr(18, 1'b1, 32'h0400_0000);
        wr(18, 1'b0, 32'h0000_0030);
        wr(19, 1'b1, 32'h0500_0000);
        wr(19, 1'b0, 32'h0000_0031);
        msg_ready = 1'b0;
        pulse(18);
        tick(30);
        pulse(19);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R10", {11'b0, msg_valid, msg_vector, msg_mode, msg_dest_logical, msg_dest},
                  {11'b0, 1'b1, 8'h30, 3'b000, 1'b0, 8'h04});
            tick(1);
        end
        expect_msg(8'h30, 3'b000, 1'b0, 8'h04);
        expect_msg(8'h31, 3'b000, 1'b0, 8'h05);
        msg_ready = 1'b1;
        drained("R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule